// File: doc/BRIEF.md
# Watchdog Timer with Command and Status Register

This block is a watchdog counter that software controls through one byte-wide register. The register holds three kinds of bits. Three enable bits turn on counting, the reset request and the board-fail indication. A sticky time-out flag shows that the counter expired. Two command bits act only at the moment they are written: one restarts the counter and the other clears the flag. The counter advances on a prescaled tick-enable input. It expires when it has seen `TERM` ticks since it was last restarted.

When the counter expires, the block always sets the time-out flag. If the reset enable is set, it also sends a one-cycle local reset request. The board-fail output follows the time-out flag while its own enable bit is set. After expiry the counter stops and waits, so one expiry gives exactly one reset request. It runs again when software restarts it or enables the watchdog again.

The block has two resets. An asynchronous power-up reset clears everything. A synchronous local reset clears only the three enable bits, so the time-out flag can still be read after the local reset that the watchdog requested.

Top module: `wdt_ctrl`

## Requirements
- R1: After power-up reset the register reads 0x00 and both `rst_req` and `brd_fail` are 0.
- R2: Register layout: bit 0 is the watchdog enable, bit 1 the reset enable, bit 3 the board-fail enable (all three read/write), and bit 4 the time-out flag (read-only). Bits 5 and 6 are command strobes, and bits 7 and 2 are unused. Bits 7, 6, 5 and 2 always read 0. `rdata` shows the register while `sel` and `rd` are both 1, and reads 0 otherwise.
- R3: The counter advances only on cycles where `tick` is 1 and bit 0 is 1. While bit 0 is 0, no time-out occurs.
- R4: A write with bit 5 set restarts the counter from zero. The time-out happens on the clock edge that takes the `TERM`-th tick after the last restart.
- R5: The time-out flag (bit 4) stays 1 until a write with bit 6 set. A write with bit 6 clear does not change it, and writing bit 4 directly has no effect.
- R6: At expiry, if bit 1 is 1, `rst_req` is 1 for exactly one cycle, starting in the cycle after the expiry edge. If bit 1 is 0, `rst_req` stays 0.
- R7: `brd_fail` is 1 exactly while bit 3 and the time-out flag are both 1.
- R8: `loc_rst` clears bits 0, 1 and 3 on the next edge. The time-out flag keeps its value.
- R9: After expiry the counter holds and gives no further time-out or reset request until a restart. A write that takes bit 0 from 0 to 1 also restarts the counter from zero.
- R10: If a restart write and a tick fall on the same edge, the restart wins. If a flag-clear write and an expiry fall on the same edge, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| loc_rst | input | 1 | Synchronous local reset, active high; clears the enable bits |
| tick | input | 1 | Prescaled time base; one count per cycle where it is high |
| sel | input | 1 | Register select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe, takes effect at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| rst_req | output | 1 | One-cycle local reset request |
| brd_fail | output | 1 | Board-fail indication |

## Verification
A write or tick takes effect at the clock edge that samples it. The register contents and `brd_fail` show the new state in the same cycle that follows that edge. `rst_req` is a register driven from the expiry condition, so it rises in the cycle right after the expiry edge and falls one cycle later. The bench drives inputs on the falling edge, updates its behavioural model on the rising edge, and compares `rdata`, `rst_req` and `brd_fail` one nanosecond after each falling edge, so every result is read in the cycle it is due. The directed steps count ticks exactly, including the single-tick boundary before expiry and the same-edge collisions.

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
  parameter int unsigned TERM = 50000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       loc_rst,
  input  logic       tick,
  input  logic       sel,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rst_req,
  output logic       brd_fail
);
  localparam int unsigned CW = $clog2(TERM + 1);
  localparam logic [CW-1:0] LAST = CW'(TERM - 1);
  localparam int B_EN   = 0;
  localparam int B_RSE  = 1;
  localparam int B_BFE  = 3;
  localparam int B_TO   = 4;
  localparam int B_RST  = 5;
  localparam int B_CLR  = 6;

  logic          en_q, rse_q, bfe_q, to_q, exp_q;
  logic [CW-1:0] cnt_q;

  wire wr_hit  = sel && wr;
  wire restart = wr_hit && (wdata[B_RST] || (wdata[B_EN] && !en_q));
  wire adv     = en_q && tick && !exp_q && !restart;
  wire expire  = adv && (cnt_q == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q  <= 1'b0;
      rse_q <= 1'b0;
      bfe_q <= 1'b0;
    end else if (loc_rst) begin
      en_q  <= 1'b0;
      rse_q <= 1'b0;
      bfe_q <= 1'b0;
    end else if (wr_hit) begin
      en_q  <= wdata[B_EN];
      rse_q <= wdata[B_RSE];
      bfe_q <= wdata[B_BFE];
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (expire) begin
      exp_q <= 1'b1;
    end else if (adv) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      to_q    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (expire)                      to_q <= 1'b1;
      else if (wr_hit && wdata[B_CLR]) to_q <= 1'b0;
      rst_req <= expire && rse_q;
    end
  end

  assign brd_fail = bfe_q && to_q;
  assign rdata    = (sel && rd) ? {3'b000, to_q, bfe_q, 1'b0, rse_q, en_q} : 8'h00;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> !rst_req);                                               // R6
  AST_REQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> to_q);                                                   // R6
  AST_NO_TO_DISABLED: assert property (@(posedge clk) disable iff (!por_n)
    $rose(to_q) |-> $past(en_q));                                        // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (to_q && !(sel && wr && wdata[B_CLR])) |=> to_q);                    // R5
  AST_RESTART_BLOCKS: assert property (@(posedge clk) disable iff (!por_n)
    (sel && wr && wdata[B_RST] && !to_q) |=> !to_q);                     // R4
  AST_LRST_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    loc_rst |=> (!en_q && !rse_q && !bfe_q && !brd_fail));               // R8
  AST_HOLD_EXPIRED: assert property (@(posedge clk) disable iff (!por_n)
    (exp_q && !(sel && wr)) |=> ($stable(cnt_q) && !rst_req));           // R9
endmodule

// File: tb/wdt_ctrl_bench.sv
module wdt_ctrl_bench;
  localparam int TERM = 6;

  logic clk = 1'b0, por_n = 1'b0, loc_rst = 1'b0, tick = 1'b0;
  logic sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic rst_req, brd_fail;

  int vectors = 0, errs = 0, cyc = 0;
  int m_en = 0, m_rse = 0, m_bfe = 0, m_to = 0, m_exp = 0, m_cnt = 0, m_rq = 0;

  always #4 clk = ~clk;

  wdt_ctrl #(.TERM(TERM)) u_wdt_ctrl (
    .clk(clk), .por_n(por_n), .loc_rst(loc_rst), .tick(tick),
    .sel(sel), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata),
    .rst_req(rst_req), .brd_fail(brd_fail)
  );

  function automatic int model_reg();
    return (m_to << 4) | (m_bfe << 3) | (m_rse << 1) | m_en;
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_en = 0; m_rse = 0; m_bfe = 0; m_to = 0; m_exp = 0; m_cnt = 0; m_rq = 0;
    end else begin
      automatic bit w = sel && wr;
      automatic bit rs = w && (wdata[5] || (wdata[0] && m_en == 0));
      automatic bit ex = (m_en == 1) && tick && (m_exp == 0) && !rs && (m_cnt == TERM - 1);
      m_rq = (ex && m_rse == 1) ? 1 : 0;
      if (ex) m_to = 1;
      else if (w && wdata[6]) m_to = 0;
      if (rs) begin m_cnt = 0; m_exp = 0; end
      else if (ex) m_exp = 1;
      else if (m_en == 1 && tick && m_exp == 0) m_cnt = m_cnt + 1;
      if (loc_rst) begin m_en = 0; m_rse = 0; m_bfe = 0; end
      else if (w) begin m_en = wdata[0]; m_rse = wdata[1]; m_bfe = wdata[3]; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (por_n) begin
      chk("R6 rst_req vs model", int'(rst_req), m_rq);
      chk("R7 brd_fail vs model", int'(brd_fail), m_bfe & m_to);
      chk("R2 rdata vs model", int'(rdata), (sel && rd) ? model_reg() : 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs++;
      $display("FAIL watchdog R1..all actual=%0d expected=<20000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  task automatic wreg(input logic [7:0] d, input logic t = 1'b0);
    @(negedge clk); sel = 1; wr = 1; wdata = d; tick = t;
    @(negedge clk); sel = 0; wr = 0; wdata = 8'h00; tick = 0;
  endtask

  task automatic rchk(input string tag, input int exp);
    @(negedge clk); sel = 1; rd = 1;
    #2 chk(tag, int'(rdata), exp);
    @(negedge clk); sel = 0; rd = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 rst_req after reset", int'(rst_req), 0);
    chk("R1 brd_fail after reset", int'(brd_fail), 0);
    por_n = 1;
    rchk("R1 register after reset", 8'h00);

    wreg(8'hFF);
    rchk("R2 layout readback", 8'h0B);
    ticks(TERM - 1);
    #1 chk("R4 no timeout one tick early", int'(brd_fail), 0);
    ticks(1);
    #1 chk("R6 rst_req pulse after expiry", int'(rst_req), 1);
    chk("R7 brd_fail on timeout", int'(brd_fail), 1);
    @(negedge clk); #1 chk("R6 rst_req single cycle", int'(rst_req), 0);
    ticks(10);
    #1 chk("R9 no repeat pulse", int'(rst_req), 0);
    rchk("R4 flag set", 8'h1B);

    wreg(8'h0B);
    rchk("R5 zero to clear bit keeps flag", 8'h1B);
    wreg(8'h4B);
    rchk("R5 clear command", 8'h0B);
    wreg(8'h1B);
    rchk("R5 direct flag write ignored", 8'h0B);
    ticks(10);
    rchk("R9 held counter gives no timeout", 8'h0B);

    wreg(8'h2B);
    ticks(4);
    wreg(8'h2B, 1'b1);
    ticks(TERM - 1);
    rchk("R10 restart beats tick", 8'h0B);
    ticks(1);
    rchk("R4 timeout after restart", 8'h1B);

    wreg(8'h4B);
    wreg(8'h29);
    ticks(TERM);
    #1 chk("R6 no request when disabled", int'(rst_req), 0);
    chk("R7 fail follows flag", int'(brd_fail), 1);
    rchk("R6 flag without reset enable", 8'h19);

    @(negedge clk); loc_rst = 1;
    @(negedge clk); loc_rst = 0;
    #1 chk("R8 brd_fail after local reset", int'(brd_fail), 0);
    rchk("R8 local reset keeps flag", 8'h10);

    wreg(8'h40);
    ticks(20);
    rchk("R3 no timeout while disabled", 8'h00);

    wreg(8'h01);
    ticks(3);
    wreg(8'h00);
    ticks(5);
    wreg(8'h01);
    ticks(TERM - 1);
    rchk("R9 re-enable restarts count", 8'h01);
    wreg(8'h41, 1'b1);
    rchk("R10 expiry beats flag clear", 8'h11);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule